// File: doc/BRIEF.md
# Interval-Spread Pulse FIFO

This block takes the pulse decisions a compute engine makes near the start of each multiplex frame and spreads them evenly across that frame. The engine can write up to eight two-bit entries in quick succession. Each entry holds one sign bit for each of two pulse channels. The block then moves one entry to the two pulse output flip-flops every time a programmable interval expires, so the pulses are not bunched together.

The interval register does two jobs. It sets the wait between the frame-start strobe and the first output update, and it sets the gap between later updates. One unit of the interval equals four enabled cycles of the filter clock. An interval of zero turns the spreading off: each write then reaches the output flip-flops directly.

A single polarity bit selects whether both pins are active high or active low. An overflow flag records that a write was lost because the queue was full.

Top module: `pulse_spreader`

## Requirements
- R1: While reset is asserted and right after it, the queue is empty, no update is scheduled, the overflow flag is 0 and both pins sit at the inactive level for the current polarity.
- R2: With `pol_inv`=1 both pins are active high. With `pol_inv`=0 both are active low. The bit acts on both pins at once, with no clock delay.
- R3: Bit 0 of `wr_sign` belongs to channel 0 (pin bit 0) and bit 1 to channel 1. A 1 means the pulse is asserted. Entries leave in the order they were written.
- R4: A `frame_start` empties the queue and reloads the countdown with 4 × `interval`. A write in the same cycle as `frame_start` is kept as the first entry.
- R5: The first update happens at the clock edge where the 4 × `interval`-th enabled (`fir_ce`=1) cycle after `frame_start` is sampled. Later updates repeat every 4 × `interval` enabled cycles. Cycles with `fir_ce`=0 do not count.
- R6: An update moves the oldest entry into both output flip-flops. If the queue is empty at an update, both outputs return to the inactive level.
- R7: A write is dropped when the queue already holds `DEPTH` (8) entries, even if a pop happens in the same cycle. The drop sets `overflow`, which stays 1 until reset.
- R8: With `interval`=0, a write reaches the pins at the next clock edge and is not queued, and `frame_start` leaves the pins unchanged.
- R9: Before the first `frame_start` after reset no update occurs, so queued writes do not reach the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of a multiplex frame |
| wr_en | input | 1 | Write strobe from the engine |
| wr_sign | input | CH | Sign bits, one per channel |
| interval | input | IVL_W | Update spacing in units of 4 filter cycles; 0 = bypass |
| fir_ce | input | 1 | Filter clock enable |
| pol_inv | input | 1 | 1 = active-high pins, 0 = active-low pins |
| pulse_out | output | CH | Pulse pins |
| overflow | output | 1 | Sticky flag for dropped writes |

## Verification
The spreading function is tried with a short burst written after the frame start and with a burst whose first entry lands on the frame-start cycle. These cases separate correct clearing and ordering from stale or reordered entries. A nine-write burst at a long interval tells a dropped ninth entry apart from one that was wrongly accepted. A frame restart after only part of the interval checks that the countdown really reloads. A run with `fir_ce` high on alternate cycles tells counting enabled cycles apart from counting clocks. Bypass writes, followed by a queued frame, show that zero-interval writes go straight to the pins and never enter the queue.

// File: rtl/pulse_spreader.sv
module pulse_spreader #(
  parameter int DEPTH = 8,
  parameter int IVL_W = 8,
  parameter int CH    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             wr_en,
  input  logic [CH-1:0]    wr_sign,
  input  logic [IVL_W-1:0] interval,
  input  logic             fir_ce,
  input  logic             pol_inv,
  output logic [CH-1:0]    pulse_out,
  output logic             overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = IVL_W + 2;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [CH-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [PW:0]   occ;
  logic [CW-1:0] cnt;
  logic [CH-1:0] act;

  wire            bypass = (interval == '0);
  wire [CW-1:0]   reload = {interval, 2'b00};
  wire            full   = (occ == FULL);
  wire            tick   = !bypass && !frame_start && fir_ce && (cnt == CW'(1));
  wire            push   = wr_en && !bypass && (frame_start || !full);
  wire            pop    = tick && (occ != '0);

  always_ff @(posedge clk) begin
    if (push) mem[frame_start ? '0 : wr_ptr] <= wr_sign;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else if (frame_start) begin
      rd_ptr <= '0;
      wr_ptr <= push ? PW'(1) : '0;
      occ    <= push ? (PW+1)'(1) : '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      if (push && !pop)      occ <= occ + (PW+1)'(1);
      else if (pop && !push) occ <= occ - (PW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (frame_start)            cnt <= reload;
    else if (tick)                   cnt <= reload;
    else if (fir_ce && cnt != '0 && !bypass) cnt <= cnt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (wr_en && !bypass && !frame_start && full) overflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                act <= '0;
    else if (bypass && wr_en)  act <= wr_sign;
    else if (tick)             act <= pop ? mem[rd_ptr] : '0;
  end

  assign pulse_out = pol_inv ? act : ~act;
endmodule

// File: rtl/pulse_spreader_chk.sv
module pulse_spreader_chk #(
  parameter int DEPTH = 8,
  parameter int IVL_W = 8,
  parameter int CH    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     frame_start,
  input logic                     wr_en,
  input logic [CH-1:0]            wr_sign,
  input logic [IVL_W-1:0]         interval,
  input logic                     pol_inv,
  input logic [CH-1:0]            pulse_out,
  input logic                     overflow,
  input logic [$clog2(DEPTH):0]   occ,
  input logic [CH-1:0]            act
);
  localparam logic [$clog2(DEPTH):0] FULL = ($clog2(DEPTH)+1)'(DEPTH);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL && wr_en && !frame_start && interval != '0) |=> overflow);

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL);

  // R4
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> occ <= ($clog2(DEPTH)+1)'(1));

  // R8
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (interval == '0 && wr_en) |=> act == $past(wr_sign));

  // R8
  bypass_noqueue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (interval == '0 && !frame_start && occ == '0) |=> occ == '0);

  // R2
  polarity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_inv != $past(pol_inv) && act == $past(act)) |-> pulse_out == ~$past(pulse_out));
endmodule

bind pulse_spreader pulse_spreader_chk #(.DEPTH(DEPTH), .IVL_W(IVL_W), .CH(CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
  .wr_sign(wr_sign), .interval(interval), .pol_inv(pol_inv),
  .pulse_out(pulse_out), .overflow(overflow), .occ(occ), .act(act)
);

// File: tb/pulse_spreader_test.sv
module pulse_spreader_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sign = 2'b00;
  logic [7:0] interval = 8'd0;
  logic       pol_inv = 1'b0;
  logic       half_mode = 1'b0;
  logic       ce_phase = 1'b0;
  logic       fir_ce;
  logic [1:0] pulse_out;
  logic       overflow;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int c; logic [1:0] v; string tag; } exp_t;
  exp_t sbq[$];

  assign fir_ce = !half_mode || ce_phase;

  pulse_spreader uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_en(wr_en),
    .wr_sign(wr_sign), .interval(interval), .fir_ce(fir_ce),
    .pol_inv(pol_inv), .pulse_out(pulse_out), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ce_phase <= ~ce_phase;

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].c <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (e.c < cyc) begin
        errors++;
        $display("FAIL %s: cycle %0d missed, actual %b expected %b", e.tag, e.c, pulse_out, e.v);
      end else if (pulse_out !== e.v) begin
        errors++;
        $display("FAIL %s: cycle %0d pulse_out=%b expected %b", e.tag, e.c, pulse_out, e.v);
      end
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic expect_at(int c, logic [1:0] v, string tag);
    exp_t e;
    e.c = c; e.v = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic check_ovf(logic exp, string tag);
    checks++;
    if (overflow !== exp) begin
      errors++;
      $display("FAIL %s: overflow=%b expected %b", tag, overflow, exp);
    end
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_frame(output int e0);
    frame_start = 1'b1;
    e0 = cyc + 1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic do_write(logic [1:0] v);
    wr_en = 1'b1; wr_sign = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    int e0, eb, e, off;
    logic [1:0] seq [9];
    @(negedge clk);
    @(negedge clk);
    // R1: inactive level in reset (active low -> 11)
    expect_at(cyc + 1, 2'b11, "R1");
    @(negedge clk);
    @(negedge clk);
    check_ovf(1'b0, "R1");
    rst_n = 1'b1;
    expect_at(cyc + 2, 2'b11, "R1");

    // R9: queued write without any frame start never surfaces
    interval = 8'd2;
    do_write(2'b11);
    expect_at(cyc + 10, 2'b11, "R9");
    expect_at(cyc + 20, 2'b11, "R9");
    wait_until(cyc + 21);

    // R3 R5 R6 R4 with active-low pins, interval 2
    do_frame(e0);
    expect_at(e0 + 7,  2'b11, "R5");
    expect_at(e0 + 8,  2'b10, "R3");
    expect_at(e0 + 15, 2'b10, "R5");
    expect_at(e0 + 16, 2'b01, "R3");
    expect_at(e0 + 24, 2'b00, "R6");
    expect_at(e0 + 32, 2'b11, "R6");
    do_write(2'b01);
    do_write(2'b10);
    do_write(2'b11);
    wait_until(e0 + 34);

    // R2: switch to active high, idle output reads 00
    pol_inv = 1'b1;
    @(negedge clk);
    expect_at(cyc + 2, 2'b00, "R2");
    @(negedge clk);
    @(negedge clk);

    // R4: write on the frame-start cycle is kept, interval 1
    interval = 8'd1;
    wr_en = 1'b1; wr_sign = 2'b10;
    do_frame(e0);
    wr_sign = 2'b01;
    @(negedge clk);
    wr_en = 1'b0;
    expect_at(e0 + 3,  2'b00, "R5");
    expect_at(e0 + 4,  2'b10, "R4");
    expect_at(e0 + 8,  2'b01, "R3");
    expect_at(e0 + 12, 2'b00, "R6");
    wait_until(e0 + 14);

    // R7: nine writes at interval 3, ninth dropped
    interval = 8'd3;
    seq[0] = 2'b01; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b01;
    seq[4] = 2'b10; seq[5] = 2'b11; seq[6] = 2'b01; seq[7] = 2'b10;
    seq[8] = 2'b11;
    do_frame(e0);
    for (int k = 0; k < 8; k++) expect_at(e0 + 12 * (k + 1), seq[k], "R7");
    expect_at(e0 + 108, 2'b00, "R7");
    for (int k = 0; k < 8; k++) do_write(seq[k]);
    check_ovf(1'b0, "R7");
    do_write(seq[8]);
    check_ovf(1'b1, "R7");
    wait_until(e0 + 110);

    // R4: restart reloads the countdown and empties the queue
    interval = 8'd2;
    do_frame(e0);
    expect_at(e0 + 8, 2'b11, "R6");
    do_write(2'b11);
    wait_until(e0 + 8);
    do_write(2'b01);
    do_write(2'b10);
    do_frame(eb);
    expect_at(eb + 5, 2'b11, "R4");
    expect_at(eb + 7, 2'b11, "R4");
    expect_at(eb + 8, 2'b00, "R4");
    wait_until(eb + 10);
    check_ovf(1'b1, "R7");

    // R5: only enabled filter cycles count
    half_mode = 1'b1;
    interval = 8'd1;
    @(negedge clk);
    @(negedge clk);
    frame_start = 1'b1;
    e0 = cyc + 1;
    #1;
    off = fir_ce ? 8 : 7;
    @(negedge clk);
    frame_start = 1'b0;
    expect_at(e0 + off - 1, 2'b00, "R5");
    expect_at(e0 + off,     2'b11, "R5");
    do_write(2'b11);
    wait_until(e0 + off + 2);
    half_mode = 1'b0;

    // R8: bypass writes go straight to the pins
    pol_inv = 1'b0;
    interval = 8'd0;
    @(negedge clk);
    @(negedge clk);
    e = cyc + 1;
    expect_at(e,     2'b01, "R8");
    expect_at(e + 1, 2'b10, "R8");
    expect_at(e + 5, 2'b10, "R8");
    do_write(2'b10);
    do_write(2'b01);
    do_frame(e0);
    wait_until(e + 6);

    // R8: bypass writes never entered the queue
    interval = 8'd1;
    do_frame(e0);
    expect_at(e0 + 4, 2'b11, "R8");
    wait_until(e0 + 6);

    while (sbq.size() > 0) @(negedge clk);
    done = 1;
    finish_up();
  end
endmodule